// File: doc/BRIEF.md
# Wired-to-MSI interrupt translator

This block converts a bank of wired interrupt lines into memory-write message requests. Every line owns a 32-bit configuration word. The word holds an enable bit, a trigger-mode bit, a group number and a payload. Beside the configuration words sit three 64-bit target addresses: a set address and a clear address for the non-secure group, and a set address for the event group. When an enabled line sees an event, the block records it in a per-line pending array. A lowest-index-first scanner later turns the pending event into a single request on a valid/ready message port.

Non-secure lines (group 0) in level mode send a set message when the line goes high and a clear message when it goes low. Edge-mode lines and all event-group lines (group 1) send only set messages, one for each rising edge. Software programs the block through a flat register port with a write strobe and a combinational read-data output.

Top module: `wired_msi_xlate`

## Requirements
- R1: After reset, msg_valid is low and every configuration and address register reads 0.
- R2: The set address of the non-secure group is written as a low word at 0x10 and a high word at 0x14, and its clear address at 0x18 and 0x1C. The set address of the event group is at 0x50 and 0x54. The configuration word of line x is at 0x100 + 4*x. All of these read back the stored value. Other offsets read 0 and ignore writes.
- R3: Configuration word fields: bit 24 is enable, bit 28 is edge mode (1) or level mode (0), bits 31:29 are the group, and bits 23:0 are the payload. An enabled group-0 edge line sends one message per rising edge, to the non-secure set address, with msg_data equal to the payload zero-extended to 32 bits.
- R4: An enabled group-0 level line sends a message to the non-secure set address when it rises and a message to the non-secure clear address when it falls, both carrying its payload.
- R5: An enabled group-1 line sends a message to the event set address on each rising edge and never sends a message on a falling edge, whatever its mode bit holds.
- R6: A line whose enable bit is 0, including a line with an all-zero word, sends no messages. Clearing the enable bit discards an event that is pending and not yet issued.
- R7: A second rising edge that arrives while the line's set event is still pending is merged with it, so only one message is sent.
- R8: When several lines are pending, messages are issued in order of increasing line index. Only one request is outstanding at a time, and msg_addr and msg_data hold steady while msg_valid is high and msg_ready is low.
- R9: An enabled line whose group is neither 0 nor 1 sends no messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Wired interrupt lines, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted |
| msg_addr | output | 64 | Target address of the message write |
| msg_data | output | 32 | Payload of the message write |

## Verification
Single pulses on edge lines check the set address and the payload. Slow assert/deassert on level lines in each group tells paired set/clear traffic apart from set-only traffic. Stimulus held back by a stalled msg_ready sets up three cases: several lines firing in one cycle, which exposes the issue order; a double pulse on one line, which shows merging; and a disable write while an event waits, which shows the pending event being dropped. Lines with zero, disabled or unsupported-group configuration are pulsed while the scoreboard expects nothing, so any stray message is caught.

// File: rtl/wired_msi_xlate.sv
module wired_msi_xlate #(
  parameter int NUM_LINES = 207,
  parameter int RADDR_W   = 12,
  parameter int PAYLOAD_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 reg_we,
  input  logic [RADDR_W-1:0]   reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [63:0]          msg_addr,
  output logic [31:0]          msg_data
);
  localparam int LW       = $clog2(NUM_LINES);
  localparam int EN_BIT   = 24;
  localparam int EDGE_BIT = 28;
  localparam logic [RADDR_W-1:0] NSR_SET_LO = RADDR_W'('h10);
  localparam logic [RADDR_W-1:0] NSR_SET_HI = RADDR_W'('h14);
  localparam logic [RADDR_W-1:0] NSR_CLR_LO = RADDR_W'('h18);
  localparam logic [RADDR_W-1:0] NSR_CLR_HI = RADDR_W'('h1C);
  localparam logic [RADDR_W-1:0] EVT_SET_LO = RADDR_W'('h50);
  localparam logic [RADDR_W-1:0] EVT_SET_HI = RADDR_W'('h54);
  localparam logic [RADDR_W-1:0] CFG_BASE   = RADDR_W'('h100);

  logic [31:0] cfg [NUM_LINES];
  logic [63:0] nsr_set_addr, nsr_clr_addr, evt_set_addr;
  logic [NUM_LINES-1:0] irq_q, set_pend, clr_pend;
  logic [NUM_LINES-1:0] live, clr_cap, take_set, take_clr;
  logic msg_clr;

  logic [RADDR_W-1:0] cfg_off;
  logic [RADDR_W-3:0] cfg_word;
  logic               cfg_hit;
  logic [LW-1:0]      cfg_idx;

  assign cfg_off  = reg_addr - CFG_BASE;
  assign cfg_word = cfg_off[RADDR_W-1:2];
  assign cfg_hit  = (reg_addr >= CFG_BASE) && (reg_addr[1:0] == 2'b00) &&
                    ({2'b00, cfg_word} < RADDR_W'(NUM_LINES));
  assign cfg_idx  = cfg_word[LW-1:0];

  always_comb begin
    case (reg_addr)
      NSR_SET_LO: reg_rdata = nsr_set_addr[31:0];
      NSR_SET_HI: reg_rdata = nsr_set_addr[63:32];
      NSR_CLR_LO: reg_rdata = nsr_clr_addr[31:0];
      NSR_CLR_HI: reg_rdata = nsr_clr_addr[63:32];
      EVT_SET_LO: reg_rdata = evt_set_addr[31:0];
      EVT_SET_HI: reg_rdata = evt_set_addr[63:32];
      default:    reg_rdata = cfg_hit ? cfg[cfg_idx] : 32'h0;
    endcase
  end

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      live[i]    = cfg[i][EN_BIT] && (cfg[i][31:30] == 2'b00);
      clr_cap[i] = live[i] && !cfg[i][29] && !cfg[i][EDGE_BIT];
    end
  end

  logic          found;
  logic [LW-1:0] pick;
  logic          load;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (set_pend[i] || clr_pend[i]) begin
        found = 1'b1;
        pick  = LW'(i);
      end
    end
  end

  assign load = !msg_valid && found;

  always_comb begin
    take_set = '0;
    take_clr = '0;
    if (load) begin
      if (set_pend[pick]) take_set[pick] = 1'b1;
      else                take_clr[pick] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) cfg[i] <= '0;
      nsr_set_addr <= '0;
      nsr_clr_addr <= '0;
      evt_set_addr <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        NSR_SET_LO: nsr_set_addr[31:0]  <= reg_wdata;
        NSR_SET_HI: nsr_set_addr[63:32] <= reg_wdata;
        NSR_CLR_LO: nsr_clr_addr[31:0]  <= reg_wdata;
        NSR_CLR_HI: nsr_clr_addr[63:32] <= reg_wdata;
        EVT_SET_LO: evt_set_addr[31:0]  <= reg_wdata;
        EVT_SET_HI: evt_set_addr[63:32] <= reg_wdata;
        default: if (cfg_hit) cfg[cfg_idx] <= reg_wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q    <= '0;
      set_pend <= '0;
      clr_pend <= '0;
    end else begin
      irq_q    <= irq_in;
      set_pend <= ((set_pend & ~take_set) | (irq_in & ~irq_q)) & live;
      clr_pend <= ((clr_pend & ~take_clr) | (~irq_in & irq_q)) & clr_cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_clr   <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_clr   <= !set_pend[pick];
      msg_data  <= 32'(cfg[pick][PAYLOAD_W-1:0]);
      if (!set_pend[pick])    msg_addr <= nsr_clr_addr;
      else if (cfg[pick][29]) msg_addr <= evt_set_addr;
      else                    msg_addr <= nsr_set_addr;
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

module wired_msi_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [63:0] msg_addr,
  input logic [31:0] msg_data,
  input logic        msg_clr,
  input logic [63:0] nsr_set_addr,
  input logic [63:0] nsr_clr_addr,
  input logic [63:0] evt_set_addr
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  // R8
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid);

  // R4
  clear_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) && msg_clr |-> msg_addr == $past(nsr_clr_addr));

  // R5
  set_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) && !msg_clr |->
      (msg_addr == $past(nsr_set_addr)) || (msg_addr == $past(evt_set_addr)));
endmodule

bind wired_msi_xlate wired_msi_xlate_chk chk_i (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .msg_clr(msg_clr),
  .nsr_set_addr(nsr_set_addr), .nsr_clr_addr(nsr_clr_addr),
  .evt_set_addr(evt_set_addr)
);

// File: tb/wired_msi_xlate_tb_top.sv
`timescale 1ns/1ps
module wired_msi_xlate_tb_top;
  localparam int N = 207;
  localparam logic [63:0] A_SET = 64'h0000_0012_3456_0040;
  localparam logic [63:0] A_CLR = 64'h0000_0012_3456_0048;
  localparam logic [63:0] A_EVT = 64'h0000_0034_0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic msg_valid;
  logic msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int checks = 0;
  int fails = 0;
  string cur_tag = "R1";
  logic [95:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  wired_msi_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data)
  );

  function automatic logic [31:0] cfgv(input int grp, input bit edg, input bit en,
                                       input logic [23:0] pay);
    return {grp[2:0], edg, 3'b000, en, pay};
  endfunction

  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected message addr=%h data=%h expected none",
                 cur_tag, msg_addr, msg_data);
      end else begin
        logic [95:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({msg_addr, msg_data} !== e) begin
          fails++;
          $display("FAIL %s message actual=%h expected=%h", t, {msg_addr, msg_data}, e);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(posedge clk); #2;
    reg_addr = a;
    @(negedge clk);
    check(tag, reg_rdata, exp);
  endtask

  task automatic expect_msg(input string tag, input logic [63:0] a, input logic [23:0] pay);
    exp_q.push_back({a, 8'h00, pay});
    tag_q.push_back(tag);
  endtask

  task automatic set_line(input int i, input logic v);
    @(posedge clk); #2;
    irq_in[i] = v;
  endtask

  task automatic pulse(input int i);
    set_line(i, 1'b1);
    repeat (3) @(posedge clk);
    #2 irq_in[i] = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic drain(input string tag);
    for (int k = 0; k < 200; k++) begin
      if (exp_q.size() == 0 && !msg_valid) break;
      @(posedge clk);
    end
    repeat (12) @(posedge clk);
    @(negedge clk);
    check(tag, {31'd0, msg_valid} | 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 valid after reset", {31'd0, msg_valid}, 32'd0);
    #2 rst_n = 1'b1;
    rd_check("R1 cfg0 reset", 12'h100, 32'h0);
    rd_check("R1 cfg206 reset", 12'h438, 32'h0);
    rd_check("R1 set addr reset", 12'h10, 32'h0);

    cur_tag = "R2";
    wr(12'h10, A_SET[31:0]); wr(12'h14, A_SET[63:32]);
    wr(12'h18, A_CLR[31:0]); wr(12'h1C, A_CLR[63:32]);
    wr(12'h50, A_EVT[31:0]); wr(12'h54, A_EVT[63:32]);
    rd_check("R2 set hi", 12'h14, A_SET[63:32]);
    rd_check("R2 clr lo", 12'h18, A_CLR[31:0]);
    rd_check("R2 evt lo", 12'h50, A_EVT[31:0]);
    wr(12'h438, 32'hDEAD_BEEF);
    rd_check("R2 cfg206", 12'h438, 32'hDEAD_BEEF);
    wr(12'h438, 32'h0);
    wr(12'h24, 32'h1234_5678);
    rd_check("R2 unmapped 0x24", 12'h24, 32'h0);
    rd_check("R2 beyond last line", 12'h43C, 32'h0);

    cur_tag = "R3";
    wr(12'h100 + 12'd28, cfgv(0, 1'b1, 1'b1, 24'h000123));
    expect_msg("R3 edge pulse 1", A_SET, 24'h000123);
    pulse(7);
    expect_msg("R3 edge pulse 2", A_SET, 24'h000123);
    pulse(7);
    drain("R3 drained");

    cur_tag = "R4";
    wr(12'h100 + 12'd80, cfgv(0, 1'b0, 1'b1, 24'hABCDEF));
    expect_msg("R4 level set", A_SET, 24'hABCDEF);
    set_line(20, 1'b1);
    drain("R4 set drained");
    expect_msg("R4 level clear", A_CLR, 24'hABCDEF);
    set_line(20, 1'b0);
    drain("R4 clear drained");

    cur_tag = "R5";
    wr(12'h100 + 12'd120, cfgv(1, 1'b0, 1'b1, 24'h000777));
    wr(12'h100 + 12'd124, cfgv(1, 1'b1, 1'b1, 24'h000888));
    expect_msg("R5 event level rise", A_EVT, 24'h000777);
    set_line(30, 1'b1);
    drain("R5 rise drained");
    set_line(30, 1'b0);
    drain("R5 no clear on fall");
    expect_msg("R5 event edge", A_EVT, 24'h000888);
    pulse(31);
    drain("R5 edge drained");

    cur_tag = "R6";
    wr(12'h100 + 12'd164, cfgv(0, 1'b0, 1'b0, 24'h000999));
    pulse(40);
    pulse(41);
    drain("R6 zero and disabled lines silent");
    cur_tag = "R9";
    wr(12'h100 + 12'd168, cfgv(3, 1'b1, 1'b1, 24'h000AAA));
    pulse(42);
    drain("R9 unsupported group silent");

    cur_tag = "R6";
    wr(12'h100 + 12'd200, cfgv(0, 1'b1, 1'b1, 24'h000050));
    @(posedge clk); #2 msg_ready = 1'b0;
    expect_msg("R6 survivor line 7", A_SET, 24'h000123);
    pulse(7);
    pulse(50);
    wr(12'h100 + 12'd200, cfgv(0, 1'b1, 1'b0, 24'h000050));
    @(posedge clk); #2 msg_ready = 1'b1;
    drain("R6 pending dropped on disable");

    cur_tag = "R7";
    wr(12'h100 + 12'd16, cfgv(0, 1'b1, 1'b1, 24'h000004));
    wr(12'h100 + 12'd24, cfgv(1, 1'b1, 1'b1, 24'h000006));
    @(posedge clk); #2 msg_ready = 1'b0;
    expect_msg("R7 blocker line 4", A_SET, 24'h000004);
    expect_msg("R7 merged line 6", A_EVT, 24'h000006);
    pulse(4);
    pulse(6);
    pulse(6);
    @(posedge clk); #2 msg_ready = 1'b1;
    drain("R7 single merged message");

    cur_tag = "R8";
    wr(12'h100 + 12'd220, cfgv(0, 1'b1, 1'b1, 24'h000055));
    wr(12'h100 + 12'd240, cfgv(0, 1'b1, 1'b1, 24'h000060));
    wr(12'h100 + 12'd400, cfgv(1, 1'b1, 1'b1, 24'h000100));
    @(posedge clk); #2 msg_ready = 1'b0;
    expect_msg("R8 first line 55", A_SET, 24'h000055);
    expect_msg("R8 second line 60", A_SET, 24'h000060);
    expect_msg("R8 third line 100", A_EVT, 24'h000100);
    @(posedge clk); #2;
    irq_in[100] = 1'b1; irq_in[60] = 1'b1; irq_in[55] = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R8 valid held while stalled", {31'd0, msg_valid}, 32'd1);
    check("R8 stalled data is lowest line", msg_data, 32'h0000_0055);
    @(posedge clk); #2 msg_ready = 1'b1;
    drain("R8 order drained");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule